// File: doc/BRIEF.md
# Trap Compare and Exception Dispatch

This block evaluates a trap-word-immediate instruction and decides what the core does next. It decodes the 32-bit instruction word and sign-extends the 16-bit immediate. It then compares that immediate with a 32-bit register operand under five selectable conditions. When any selected condition holds, the block dispatches one of three actions: a program interrupt, a debug interrupt, or a halt into a debug-stop state. The choice depends on three debug-control inputs and the debug-exception enable bit of the machine state.

The block returns the next program counter, the write strobes and data for the two save/restore register pairs, and the new machine-state word. It also returns set strobes for the exception-syndrome trap bit and for the debug-status trap-event and imprecise-event bits. All outputs are registered. They change on the clock edge that samples the instruction-valid strobe, and a one-cycle pulse with a two-bit code reports the action taken. Data outputs keep their last value between instructions. Strobes are high only in the cycle that follows an accepted instruction.

Top module: `trap_dispatch`

## Requirements
- R1: The instruction word uses bit 31 as its most significant bit. Only a word with `inst_valid` high and primary opcode `inst_word[31:26]` equal to 3 is acted upon. Any other word raises no `act_valid` and no write strobe, and leaves all data outputs unchanged.
- R2: The immediate `inst_word[15:0]` is sign-extended to 32 bits. The condition field is `inst_word[25:21]`, and a trap occurs when at least one of its set bits selects a true condition. The bits select, from 25 down to 21: signed `ra_val` less than the immediate, signed greater than, equal, unsigned less than, and unsigned greater than. `act_code` reports the action: 0 = no trap, 1 = program interrupt, 2 = debug interrupt, 3 = debug stop.
- R3: Without a trap, `next_pc` is `inst_addr`+4. No strobe other than `act_valid` is raised in that case.
- R4: A trap is a program interrupt when `dbg_trap_en` is 0, or when both `dbg_ext_mode` and `dbg_int_mode` are 0. In that case the block raises `srr01_we` with `save_pc`=`inst_addr` and `save_msr`=`msr_in`, and raises `esr_trap_set`. It also raises `msr_we`, with `msr_new` equal to `msr_in` with bits 18, 15, 14, 5 and 4 cleared. `next_pc` = {`vec_prefix[31:16]`, 16'h0700}.
- R5: With `dbg_trap_en`=1, `dbg_ext_mode`=0, `dbg_int_mode`=1 and `msr_in[9]`=1 (debug exceptions enabled), a trap is a debug interrupt. The block raises `srr23_we` with `save_pc`=`inst_addr` and `save_msr`=`msr_in`, and raises `dbsr_trap_set` and `msr_we`. `msr_new` is `msr_in` with bits 18, 17, 15, 14, 9, 5 and 4 cleared. `next_pc` = {`vec_prefix[31:16]`, 16'h2000}.
- R6: With `dbg_trap_en`=1 and `dbg_ext_mode`=1, a trap enters debug stop. The block raises `dbsr_trap_set` and sets `next_pc`=`inst_addr`, with no save/restore or machine-state write. `dbsr_impr_set` is raised as well when `dbg_int_mode`=1 and `msr_in[9]`=0.
- R7: With `dbg_trap_en`=1, `dbg_ext_mode`=0, `dbg_int_mode`=1 and `msr_in[9]`=0, a trap is the program interrupt of R4 and additionally raises `dbsr_impr_set`.
- R8: During and after reset all outputs are 0. Every output is registered. Strobes last exactly one cycle after each accepted instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | Instruction present this cycle |
| inst_word | input | 32 | Instruction word, bit 31 most significant |
| inst_addr | input | 32 | Address of the instruction |
| ra_val | input | 32 | Register operand |
| msr_in | input | 32 | Current machine-state word |
| vec_prefix | input | 32 | Vector prefix; upper half used |
| dbg_trap_en | input | 1 | Trap is a debug event |
| dbg_ext_mode | input | 1 | External debug mode |
| dbg_int_mode | input | 1 | Internal debug mode |
| act_valid | output | 1 | One-cycle action pulse |
| act_code | output | 2 | Action taken |
| next_pc | output | 32 | Next program counter |
| srr01_we | output | 1 | Write first save/restore pair |
| srr23_we | output | 1 | Write second save/restore pair |
| save_pc | output | 32 | Saved instruction address |
| save_msr | output | 32 | Saved machine state |
| msr_we | output | 1 | Machine-state write |
| msr_new | output | 32 | New machine-state word |
| esr_trap_set | output | 1 | Set syndrome trap bit |
| dbsr_trap_set | output | 1 | Set debug trap-event bit |
| dbsr_impr_set | output | 1 | Set debug imprecise-event bit |

## Verification
Operands are drawn equal to the sign-extended immediate, one above it, one below it, at the signed extremes, and at random. This separates equality from the ordered conditions, and separates the signed comparisons from the unsigned ones where the sign bit differs. Condition fields range over all 32 values, so a trap that fires because of an unselected condition shows up. Every combination of the three debug controls and the debug-exception bit is driven, which distinguishes the four dispatch paths and the two imprecise-event cases. Other opcodes are mixed in to show that they leave every output unchanged.

// File: rtl/trap_dispatch.sv
module trap_dispatch #(
  parameter logic [15:0] PGM_OFS = 16'h0700,
  parameter logic [15:0] DBG_OFS = 16'h2000,
  parameter int          DE_BIT  = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inst_valid,
  input  logic [31:0] inst_word,
  input  logic [31:0] inst_addr,
  input  logic [31:0] ra_val,
  input  logic [31:0] msr_in,
  input  logic [31:0] vec_prefix,
  input  logic        dbg_trap_en,
  input  logic        dbg_ext_mode,
  input  logic        dbg_int_mode,
  output logic        act_valid,
  output logic [1:0]  act_code,
  output logic [31:0] next_pc,
  output logic        srr01_we,
  output logic        srr23_we,
  output logic [31:0] save_pc,
  output logic [31:0] save_msr,
  output logic        msr_we,
  output logic [31:0] msr_new,
  output logic        esr_trap_set,
  output logic        dbsr_trap_set,
  output logic        dbsr_impr_set
);
  localparam logic [1:0] A_NONE = 2'd0, A_PGM = 2'd1, A_DBG = 2'd2, A_STOP = 2'd3;
  localparam logic [31:0] PGM_CLR = (32'd1 << 18) | (32'd1 << 15) | (32'd1 << 14) | (32'd1 << 5) | (32'd1 << 4);
  localparam logic [31:0] DBG_CLR = PGM_CLR | (32'd1 << 17) | (32'd1 << DE_BIT);

  logic [31:0] imm;
  logic [4:0]  to, cond;
  logic        take, hit, dbg_evt, de;
  logic [1:0]  kind;

  assign imm  = {{16{inst_word[15]}}, inst_word[15:0]};
  assign to   = inst_word[25:21];
  assign take = inst_valid && (inst_word[31:26] == 6'd3);
  assign de   = msr_in[DE_BIT];
  assign cond = {$signed(ra_val) < $signed(imm), $signed(ra_val) > $signed(imm),
                 ra_val == imm, ra_val < imm, ra_val > imm};
  assign hit  = |(to & cond);
  assign dbg_evt = dbg_trap_en && (dbg_ext_mode || dbg_int_mode);

  always_comb begin
    if (!hit)                kind = A_NONE;
    else if (!dbg_evt)       kind = A_PGM;
    else if (dbg_ext_mode)   kind = A_STOP;
    else if (de)             kind = A_DBG;
    else                     kind = A_PGM;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_valid <= 1'b0; act_code <= A_NONE; next_pc <= '0;
      srr01_we <= 1'b0; srr23_we <= 1'b0; save_pc <= '0; save_msr <= '0;
      msr_we <= 1'b0; msr_new <= '0;
      esr_trap_set <= 1'b0; dbsr_trap_set <= 1'b0; dbsr_impr_set <= 1'b0;
    end else begin
      act_valid <= take;
      srr01_we <= 1'b0; srr23_we <= 1'b0; msr_we <= 1'b0;
      esr_trap_set <= 1'b0; dbsr_trap_set <= 1'b0; dbsr_impr_set <= 1'b0;
      if (take) begin
        act_code <= kind;
        case (kind)
          A_NONE: next_pc <= inst_addr + 32'd4;
          A_PGM: begin
            next_pc <= {vec_prefix[31:16], PGM_OFS};
            srr01_we <= 1'b1; save_pc <= inst_addr; save_msr <= msr_in;
            msr_we <= 1'b1; msr_new <= msr_in & ~PGM_CLR;
            esr_trap_set <= 1'b1;
            dbsr_impr_set <= dbg_evt;
          end
          A_DBG: begin
            next_pc <= {vec_prefix[31:16], DBG_OFS};
            srr23_we <= 1'b1; save_pc <= inst_addr; save_msr <= msr_in;
            msr_we <= 1'b1; msr_new <= msr_in & ~DBG_CLR;
            dbsr_trap_set <= 1'b1;
          end
          default: begin
            next_pc <= inst_addr;
            dbsr_trap_set <= 1'b1;
            dbsr_impr_set <= dbg_int_mode && !de;
          end
        endcase
      end
    end
  end

  p_one_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(srr01_we && srr23_we));
  p_pgm_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
    srr01_we |-> (next_pc[15:0] == PGM_OFS && esr_trap_set && act_valid));
  p_dbg_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srr23_we |-> (next_pc[15:0] == DBG_OFS && !msr_new[DE_BIT] && dbsr_trap_set));
  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_code == A_STOP) |-> (next_pc == $past(inst_addr) && !msr_we));
  p_quiet_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_code == A_NONE) |-> !(msr_we || esr_trap_set || dbsr_trap_set || dbsr_impr_set));
  p_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid |-> !(srr01_we || srr23_we || msr_we || dbsr_trap_set || esr_trap_set));
  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !$past(inst_valid)) |=> (!act_valid || $past(inst_valid)));
endmodule

// File: tb/trap_dispatch_bench.sv
`timescale 1ns/100ps
module trap_dispatch_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic inst_valid = 1'b0;
  logic [31:0] inst_word = '0, inst_addr = '0, ra_val = '0, msr_in = '0, vec_prefix = '0;
  logic dbg_trap_en = 1'b0, dbg_ext_mode = 1'b0, dbg_int_mode = 1'b0;
  logic act_valid, srr01_we, srr23_we, msr_we, esr_trap_set, dbsr_trap_set, dbsr_impr_set;
  logic [1:0] act_code;
  logic [31:0] next_pc, save_pc, save_msr, msr_new;

  trap_dispatch u_trap_dispatch (.*);

  always #2.5 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  logic        e_valid, e_s01, e_s23, e_mwe, e_esr, e_dtr, e_dim;
  logic [1:0]  e_code;
  logic [31:0] e_pc, e_spc, e_smsr, e_msr;

  function automatic logic [31:0] clear_bits(logic [31:0] v, bit dbg);
    int idx[$] = '{18, 15, 14, 5, 4};
    if (dbg) begin idx.push_back(17); idx.push_back(9); end
    foreach (idx[i]) v[idx[i]] = 1'b0;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid = 0; e_code = 0; e_pc = 0; e_s01 = 0; e_s23 = 0; e_spc = 0; e_smsr = 0;
      e_mwe = 0; e_msr = 0; e_esr = 0; e_dtr = 0; e_dim = 0;
    end else begin
      e_s01 = 0; e_s23 = 0; e_mwe = 0; e_esr = 0; e_dtr = 0; e_dim = 0;
      e_valid = inst_valid && inst_word[31:26] == 6'd3;
      if (e_valid) begin
        int simm, sra; longint uimm, ura; bit trap, dev;
        simm = int'($signed(inst_word[15:0]));
        sra = int'(ra_val);
        uimm = longint'(unsigned'(simm));
        ura = longint'(ra_val);
        trap = (inst_word[25] && sra < simm) || (inst_word[24] && sra > simm) ||
               (inst_word[23] && sra == simm) || (inst_word[22] && ura < uimm) ||
               (inst_word[21] && ura > uimm);
        dev = dbg_trap_en && (dbg_ext_mode || dbg_int_mode);
        if (!trap) begin e_code = 0; e_pc = inst_addr + 4; end
        else if (dev && dbg_ext_mode) begin
          e_code = 3; e_pc = inst_addr; e_dtr = 1; e_dim = dbg_int_mode && !msr_in[9];
        end else if (dev && msr_in[9]) begin
          e_code = 2; e_pc = {vec_prefix[31:16], 16'h2000}; e_s23 = 1;
          e_spc = inst_addr; e_smsr = msr_in; e_mwe = 1; e_msr = clear_bits(msr_in, 1); e_dtr = 1;
        end else begin
          e_code = 1; e_pc = {vec_prefix[31:16], 16'h0700}; e_s01 = 1;
          e_spc = inst_addr; e_smsr = msr_in; e_mwe = 1; e_msr = clear_bits(msr_in, 0);
          e_esr = 1; e_dim = dev;
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1", "act_valid", act_valid, e_valid);
    chk("R2", "act_code", act_code, e_code);
    chk("R3", "next_pc", next_pc, e_pc);
    chk("R4", "srr01_we", srr01_we, e_s01);
    chk("R4", "save_pc", save_pc, e_spc);
    chk("R4", "save_msr", save_msr, e_smsr);
    chk("R4", "msr_we", msr_we, e_mwe);
    chk("R4", "msr_new", msr_new, e_msr);
    chk("R4", "esr_trap_set", esr_trap_set, e_esr);
    chk("R5", "srr23_we", srr23_we, e_s23);
    chk("R6", "dbsr_trap_set", dbsr_trap_set, e_dtr);
    chk("R7", "dbsr_impr_set", dbsr_impr_set, e_dim);
  endtask

  task automatic step(bit v, logic [5:0] opc, logic [4:0] to, logic [15:0] imm, logic [31:0] ra,
                      logic [31:0] msr, logic [2:0] dbg);
    @(negedge clk);
    compare_all();
    inst_valid = v; inst_word = {opc, to, 5'd7, imm}; ra_val = ra; msr_in = msr;
    {dbg_trap_en, dbg_ext_mode, dbg_int_mode} = dbg;
    inst_addr = inst_addr + 32'h0000_0104;
    vec_prefix = {$urandom_range(0, 65535), 16'h0};
  endtask

  initial begin
    #200000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "reset act_valid", act_valid, 1'b0);
    chk("R8", "reset next_pc", next_pc, 32'h0);
    chk("R8", "reset msr_new", msr_new, 32'h0);
    rst_n = 1'b1;
    // R2: each condition alone, around an immediate of -1
    for (int t = 0; t < 5; t++) begin
      step(1, 6'd3, 5'b10000 >> t, 16'hFFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000);
      step(1, 6'd3, 5'b10000 >> t, 16'hFFFF, 32'h0000_0001, 32'hFFFF_FFFF, 3'b000);
      step(1, 6'd3, 5'b10000 >> t, 16'hFFFF, 32'h8000_0000, 32'hFFFF_FFFF, 3'b000);
    end
    // R4..R7: every debug-control and DE combination with a sure trap
    for (int d = 0; d < 16; d++)
      step(1, 6'd3, 5'b00100, 16'h0042, 32'h42, {22'h3FFFFF, d[3], 9'h1FF}, d[2:0]);
    // R1: other opcodes ignored, R8 idle strobes
    step(1, 6'd31, 5'b11111, 16'h0, 32'h0, 32'hFFFF_FFFF, 3'b000);
    step(0, 6'd3, 5'b11111, 16'h0, 32'h0, 32'hFFFF_FFFF, 3'b000);
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] imm; logic [31:0] sx, ra;
      imm = 16'($urandom);
      sx = {{16{imm[15]}}, imm};
      case ($urandom_range(0, 5))
        0: ra = sx; 1: ra = sx + 1; 2: ra = sx - 1;
        3: ra = 32'h8000_0000; 4: ra = 32'h7FFF_FFFF; default: ra = $urandom;
      endcase
      step($urandom_range(0, 7) != 0, ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'd3,
           5'($urandom), imm, ra, $urandom, 3'($urandom));
    end
    step(0, 6'd0, 5'd0, 16'd0, 32'd0, 32'd0, 3'd0);
    @(negedge clk);
    compare_all();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule